// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address. It reads two levels of a page table that sits in ordinary memory. The upper ten address bits choose an entry in the root directory. That entry names a second-level table, and the middle ten bits choose the leaf entry inside it. The leaf supplies the frame number, and the low twelve bits pass through unchanged as the byte offset.

Each request carries an access kind (read or write) and a privilege (user or supervisor). The walker checks each fetched entry for presence. It then checks write permission and user permission at each level, so the effective rights are the AND of both levels. On a successful walk the leaf entry gets its Accessed mark, plus its Dirty mark for a write, through a single write-back, and only when a mark is missing. A failed walk returns a fault with a cause code, the level at which it stopped and the virtual address.

The controller has eight states:

| State | Action | Leaves to |
|---|---|---|
| S_IDLE | Waits for a request | S_DIR_REQ on accept |
| S_DIR_REQ | Presents the directory read | S_DIR_WAIT on handshake |
| S_DIR_WAIT | Awaits the directory word | S_FAULT on a bad entry, S_PTE_REQ otherwise |
| S_PTE_REQ | Presents the leaf read | S_PTE_WAIT on handshake |
| S_PTE_WAIT | Awaits the leaf word | S_FAULT on a bad entry, S_UPDATE when a mark is missing, S_DONE otherwise |
| S_UPDATE | Presents the leaf write | S_DONE on handshake |
| S_DONE | Holds a successful result | S_IDLE on acknowledge |
| S_FAULT | Holds a fault result | S_IDLE on acknowledge |

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req_valid are both 0.
- R2: The first memory access of a walk is a read at base + vaddr[31:22]*4. The base is the value on base_reg in the cycle the request is accepted, and later changes to base_reg do not affect that walk.
- R3: After a usable directory word arrives, the second access is a read at {dir[31:12], 12'b0} + vaddr[21:12]*4.
- R4: Entry bit 0 is Present. If it is 0 at either level, the walk ends with rsp_fault=1, rsp_cause=1 and rsp_level set to 0 for the directory or 1 for the leaf. No further memory access follows. Presence is checked before protection.
- R5: Entry bit 1 is write permission. A write access meeting a 0 in bit 1 at either level gives rsp_fault=1, rsp_cause=2 and the level of that entry.
- R6: Entry bit 2 is user permission. A user access meeting a 0 in bit 2 at either level gives a fault with cause 2. A supervisor access ignores bit 2.
- R7: On a successful walk the leaf is written back with bit 5 set, and with bit 6 set as well for a write. Every other bit, including bits 3, 4, 7, 8, 9-11 and the frame, is unchanged.
- R8: No write-back is made when the needed marks are already set, and none is made on a faulting walk.
- R9: A successful response has rsp_fault=0, rsp_cause=0, rsp_level=0 and rsp_paddr={leaf[31:12], vaddr[11:0]}. Every response returns the request's address on rsp_vaddr, and a fault response has rsp_paddr=0.
- R10: Only one walk runs at a time. req_ready is 0 from acceptance until the response handshake. The response fields stay stable while rsp_valid=1 and rsp_ready=0.
- R11: A memory request keeps its address, direction and data stable until mem_req_ready is seen. A read returns its word later on mem_rsp_valid. A write completes at the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_reg | input | 32 | Physical base of the root directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result acknowledge |
| rsp_fault | output | 1 | Walk failed |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level | output | 1 | Fault level: 0 directory, 1 leaf |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_vaddr | output | 32 | Virtual address of this result |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word address in bytes |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The bench targets these cases:

- **Protection at the directory level.** A read-only or supervisor-only directory over a fully permissive leaf must still fault at level 0. A design that checked only the leaf would return a translation.
- **Priority of presence over protection.** An entry that is absent and also read-only must report cause 1. A design with the priority reversed would report a protection fault.
- **Write-back filtering.** Repeated reads and writes to the same page must stop producing write-backs once the marks are set. A leaf with every pass-through bit set must come back with those bits intact. An unfiltered or masking update would show up as an extra or wrong memory write.
- **Base register capture.** The base register is flipped in the middle of a walk; a design that used it live would fetch from the wrong directory.
- **Handshake timing.** Memory stalls and held-off acknowledgements expose any result that changes, or any request that moves, before its handshake.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int PTE_PRESENT  = 0;
    localparam int PTE_WRITABLE = 1;
    localparam int PTE_USER     = 2;
    localparam int PTE_ACCESSED = 5;
    localparam int PTE_DIRTY    = 6;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PERM   = 2'd2
    } fault_cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_PTE_REQ,
        S_PTE_WAIT,
        S_UPDATE,
        S_DONE,
        S_FAULT
    } walk_state_e;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 12,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic [ADDR_W-1:0]       base_q,
    input  logic [ADDR_W-1:0]       vaddr_q,
    input  logic [ADDR_W-OFF_W-1:0] tbl_frame_q,
    input  logic [ADDR_W-OFF_W-1:0] leaf_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       leaf_addr,
    output logic [ADDR_W-1:0]       leaf_paddr
);
    localparam int PAD_W = ADDR_W - IDX_W - ENT_LOG2;

    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  leaf_idx;
    logic [ADDR_W-1:0] dir_off;
    logic [ADDR_W-1:0] leaf_off;
    logic [ADDR_W-1:0] tbl_base;

    always_comb begin
        dir_idx    = vaddr_q[ADDR_W-1 -: IDX_W];
        leaf_idx   = vaddr_q[OFF_W+IDX_W-1 -: IDX_W];
        dir_off    = {{PAD_W{1'b0}}, dir_idx, {ENT_LOG2{1'b0}}};
        leaf_off   = {{PAD_W{1'b0}}, leaf_idx, {ENT_LOG2{1'b0}}};
        tbl_base   = {tbl_frame_q, {OFF_W{1'b0}}};
        dir_addr   = base_q + dir_off;
        leaf_addr  = tbl_base + leaf_off;
        leaf_paddr = {leaf_frame, vaddr_q[OFF_W-1:0]};
    end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    output logic             fault,
    output fault_cause_e     cause,
    output logic [ENT_W-1:0] updated,
    output logic             need_wb
);
    logic deny_write;
    logic deny_user;

    always_comb begin
        deny_write = is_write && !entry[PTE_WRITABLE];
        deny_user  = is_user && !entry[PTE_USER];
        if (!entry[PTE_PRESENT]) begin
            fault = 1'b1;
            cause = CAUSE_ABSENT;
        end else if (deny_write || deny_user) begin
            fault = 1'b1;
            cause = CAUSE_PERM;
        end else begin
            fault = 1'b0;
            cause = CAUSE_NONE;
        end
        updated = entry;
        updated[PTE_ACCESSED] = 1'b1;
        if (is_write) begin
            updated[PTE_DIRTY] = 1'b1;
        end
        need_wb = (updated != entry);
    end

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic                    req_write,
    input  logic                    req_user,
    input  logic [ADDR_W-1:0]       base_reg,
    output logic                    req_ready,
    input  logic                    rsp_ready,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [1:0]              rsp_cause,
    output logic                    rsp_level,
    output logic [ADDR_W-1:0]       rsp_paddr,
    output logic [ADDR_W-1:0]       rsp_vaddr,
    input  logic                    mem_req_ready,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-OFF_W-1:0] rsp_frame,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [ADDR_W-1:0]       mem_req_wdata,
    input  logic [ADDR_W-1:0]       dir_addr,
    input  logic [ADDR_W-1:0]       leaf_addr,
    input  logic [ADDR_W-1:0]       leaf_paddr,
    input  logic                    ev_fault,
    input  fault_cause_e            ev_cause,
    input  logic [ADDR_W-1:0]       ev_updated,
    input  logic                    ev_need_wb,
    output logic [ADDR_W-1:0]       vaddr_q,
    output logic [ADDR_W-1:0]       base_q,
    output logic [ADDR_W-OFF_W-1:0] tbl_frame_q,
    output logic                    write_q,
    output logic                    user_q
);
    walk_state_e       state, state_nx;
    fault_cause_e      cause_q;
    logic              level_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ADDR_W-1:0] wdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = S_DIR_REQ;
            S_DIR_REQ:  if (mem_req_ready) state_nx = S_DIR_WAIT;
            S_DIR_WAIT: if (mem_rsp_valid) state_nx = ev_fault ? S_FAULT : S_PTE_REQ;
            S_PTE_REQ:  if (mem_req_ready) state_nx = S_PTE_WAIT;
            S_PTE_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ev_fault) begin
                        state_nx = S_FAULT;
                    end else if (ev_need_wb) begin
                        state_nx = S_UPDATE;
                    end else begin
                        state_nx = S_DONE;
                    end
                end
            end
            S_UPDATE:   if (mem_req_ready) state_nx = S_DONE;
            S_DONE:     if (rsp_ready) state_nx = S_IDLE;
            S_FAULT:    if (rsp_ready) state_nx = S_IDLE;
        endcase
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            base_q      <= '0;
            tbl_frame_q <= '0;
            write_q     <= 1'b0;
            user_q      <= 1'b0;
            cause_q     <= CAUSE_NONE;
            level_q     <= 1'b0;
            paddr_q     <= '0;
            wdata_q     <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        base_q  <= base_reg;
                        write_q <= req_write;
                        user_q  <= req_user;
                        cause_q <= CAUSE_NONE;
                        level_q <= 1'b0;
                        paddr_q <= '0;
                    end
                end
                S_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ev_fault) begin
                            cause_q <= ev_cause;
                            level_q <= 1'b0;
                        end else begin
                            tbl_frame_q <= rsp_frame;
                        end
                    end
                end
                S_PTE_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ev_fault) begin
                            cause_q <= ev_cause;
                            level_q <= 1'b1;
                        end else begin
                            paddr_q <= leaf_paddr;
                            wdata_q <= ev_updated;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == S_IDLE);
        rsp_valid     = (state == S_DONE) || (state == S_FAULT);
        rsp_fault     = (state == S_FAULT);
        rsp_cause     = cause_q;
        rsp_level     = level_q;
        rsp_paddr     = paddr_q;
        rsp_vaddr     = vaddr_q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        unique case (state)
            S_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr;
            end
            S_PTE_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = leaf_addr;
            end
            S_UPDATE: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = leaf_addr;
                mem_req_wdata = wdata_q;
            end
            S_IDLE, S_DIR_WAIT, S_PTE_WAIT, S_DONE, S_FAULT: ;
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 12,
    parameter int ENT_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_reg,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic              rsp_level,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_rdata
);
    localparam int IDX_W   = (ADDR_W - OFF_W) / 2;
    localparam int FRAME_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0]  vaddr_q, base_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic               write_q, user_q;
    logic [ADDR_W-1:0]  dir_addr, leaf_addr, leaf_paddr;
    logic               ev_fault, ev_need_wb;
    fault_cause_e       ev_cause;
    logic [ADDR_W-1:0]  ev_updated;

    pt_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)
    ) u_addr (
        .base_q      (base_q),
        .vaddr_q     (vaddr_q),
        .tbl_frame_q (tbl_frame_q),
        .leaf_frame  (mem_rsp_rdata[ADDR_W-1:OFF_W]),
        .dir_addr    (dir_addr),
        .leaf_addr   (leaf_addr),
        .leaf_paddr  (leaf_paddr)
    );

    pt_entry_eval #(.ENT_W(ADDR_W)) u_eval (
        .entry    (mem_rsp_rdata),
        .is_write (write_q),
        .is_user  (user_q),
        .fault    (ev_fault),
        .cause    (ev_cause),
        .updated  (ev_updated),
        .need_wb  (ev_need_wb)
    );

    pt_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_user      (req_user),
        .base_reg      (base_reg),
        .req_ready     (req_ready),
        .rsp_ready     (rsp_ready),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_cause     (rsp_cause),
        .rsp_level     (rsp_level),
        .rsp_paddr     (rsp_paddr),
        .rsp_vaddr     (rsp_vaddr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_frame     (mem_rsp_rdata[ADDR_W-1:OFF_W]),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .dir_addr      (dir_addr),
        .leaf_addr     (leaf_addr),
        .leaf_paddr    (leaf_paddr),
        .ev_fault      (ev_fault),
        .ev_cause      (ev_cause),
        .ev_updated    (ev_updated),
        .ev_need_wb    (ev_need_wb),
        .vaddr_q       (vaddr_q),
        .base_q        (base_q),
        .tbl_frame_q   (tbl_frame_q),
        .write_q       (write_q),
        .user_q        (user_q)
    );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause,
    input logic              rsp_level,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ADDR_W-1:0] rsp_vaddr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [ADDR_W-1:0] mem_req_wdata
);
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_cause)
            && $stable(rsp_level) && $stable(rsp_paddr) && $stable(rsp_vaddr));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    p_cause_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    p_wb_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[5]);

    p_quiet_at_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid);

    p_fault_paddr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_reg = 32'h0001_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        rsp_level;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #5 clk = ~clk;

    pt_walker i_pt_walker (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] mem [int unsigned];
    logic [64:0] exp_q [$];
    int          stall_mod = 0;
    int          cyc = 0;
    bit          pend = 0;
    logic [31:0] pend_addr = '0;

    logic        e_fault;
    logic [1:0]  e_cause;
    logic        e_level;
    logic [31:0] e_paddr;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // behavioural model of one walk
    task automatic predict(input logic [31:0] va, input bit w, input bit u, input logic [31:0] base);
        logic [31:0] da, la, pde, pte, nv;
        e_fault = 0; e_cause = 0; e_level = 0; e_paddr = 0;
        da = base + {20'h0, va[31:22], 2'b00};
        exp_q.push_back({1'b0, da, 32'h0});
        pde = rd(da);
        if (!pde[0]) begin
            e_fault = 1; e_cause = 2'd1;
        end else if ((w && !pde[1]) || (u && !pde[2])) begin
            e_fault = 1; e_cause = 2'd2;
        end else begin
            la = {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
            exp_q.push_back({1'b0, la, 32'h0});
            pte = rd(la);
            if (!pte[0]) begin
                e_fault = 1; e_cause = 2'd1; e_level = 1;
            end else if ((w && !pte[1]) || (u && !pte[2])) begin
                e_fault = 1; e_cause = 2'd2; e_level = 1;
            end else begin
                nv = pte | 32'h20 | (w ? 32'h40 : 32'h0);
                if (nv != pte) exp_q.push_back({1'b1, la, nv});
                e_paddr = {pte[31:12], va[11:0]};
            end
        end
    endtask

    // memory model, compared with the expected access list on every clock
    always @(negedge clk) begin
        logic [64:0] e;
        logic [64:0] got;
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = rd(pend_addr);
            pend = 0;
        end
        mem_req_ready = (stall_mod == 0) || ((cyc % stall_mod) != 0);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            got = {mem_req_write, mem_req_addr, mem_req_write ? mem_req_wdata : 32'h0};
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected memory access", {63'h0, got}, 128'h0);
            end else begin
                e = exp_q.pop_front();
                chk(got == e, e[64] ? "R7 leaf write-back" : "R2/R3 table read", {63'h0, got}, {63'h0, e});
            end
            if (mem_req_write) mem[mem_req_addr] = mem_req_wdata;
            else begin
                pend = 1;
                pend_addr = mem_req_addr;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input bit w, input bit u, input int hold,
                        input bit scramble, input string tag);
        logic [68:0] first, now, expv;
        logic [31:0] saved;
        @(negedge clk);
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R10 ready while idle", {127'h0, req_ready}, 128'h1);
        predict(va, w, u, base_reg);
        saved = base_reg;
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) base_reg = base_reg ^ 32'h0000_F000;
        while (!rsp_valid) begin
            chk(req_ready == 1'b0, "R10 busy during walk", {127'h0, req_ready}, 128'h0);
            @(negedge clk);
        end
        first = {rsp_fault, rsp_cause, rsp_level, rsp_paddr, rsp_vaddr};
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            now = {rsp_fault, rsp_cause, rsp_level, rsp_paddr, rsp_vaddr};
            chk(rsp_valid && now == first, "R10 result held", {59'h0, now}, {59'h0, first});
        end
        rsp_ready = 1'b1;
        now  = {rsp_fault, rsp_cause, rsp_level, rsp_paddr, rsp_vaddr};
        expv = {e_fault, e_cause, e_level, e_paddr, va};
        chk(now == expv, tag, {59'h0, now}, {59'h0, expv});
        chk(exp_q.size() == 0, "R8 missing memory access", exp_q.size(), 128'h0);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R10 release after acknowledge",
            {126'h0, rsp_valid, req_ready}, 128'h1);
        if (scramble) base_reg = saved;
        exp_q.delete();
    endtask

    function automatic logic [31:0] va_of(input int d, input int t, input int off);
        return {d[9:0], t[9:0], off[11:0]};
    endfunction

    initial begin
        // directory at 0x10000, second-level tables at 0x20000..
        mem[32'h0001_0004] = 32'h0002_0007;  // full rights
        mem[32'h0001_0008] = 32'h0002_1005;  // read-only
        mem[32'h0001_000C] = 32'h0002_2003;  // supervisor only
        mem[32'h0001_0018] = 32'h0002_4000;  // absent and read-only
        mem[32'h0002_0000] = 32'h0010_0007;
        mem[32'h0002_0004] = 32'h0010_1005;
        mem[32'h0002_0008] = 32'h0010_2003;
        mem[32'h0002_0010] = 32'h0010_4F9F;  // pass-through bits set
        mem[32'h0002_0014] = 32'h0010_5067;  // marks already set
        mem[32'h0002_1000] = 32'h0020_0007;
        mem[32'h0002_2000] = 32'h0030_0007;
        // second directory at 0x30000
        mem[32'h0003_0004] = 32'h0002_2007;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
            {125'h0, req_ready, rsp_valid, mem_req_valid}, 128'h4);

        walk(va_of(1, 0, 12'hABC), 0, 1, 0, 0, "R9 read translation sets accessed");
        walk(va_of(1, 0, 12'h004), 0, 1, 2, 0, "R8 repeat read no write-back");
        stall_mod = 3;
        walk(va_of(1, 0, 12'h010), 1, 1, 0, 0, "R7 write sets dirty");
        walk(va_of(1, 0, 12'h020), 1, 0, 1, 0, "R8 repeat write no write-back");
        walk(va_of(1, 1, 12'h100), 1, 1, 0, 0, "R5 write to read-only leaf");
        walk(va_of(1, 1, 12'h104), 0, 1, 0, 0, "R9 read of read-only leaf");
        stall_mod = 2;
        walk(va_of(1, 2, 12'h200), 0, 1, 3, 0, "R6 user to supervisor leaf");
        walk(va_of(1, 2, 12'h204), 1, 0, 0, 0, "R6 supervisor ignores user bit");
        walk(va_of(1, 3, 12'h000), 0, 0, 0, 0, "R4 absent leaf");
        walk(va_of(4, 0, 12'h000), 0, 0, 0, 0, "R4 absent directory");
        stall_mod = 0;
        walk(va_of(2, 0, 12'h0F0), 1, 0, 0, 0, "R5 write through read-only directory");
        walk(va_of(2, 0, 12'h0F4), 0, 1, 0, 0, "R9 read through read-only directory");
        walk(va_of(3, 0, 12'h010), 0, 1, 0, 0, "R6 user through supervisor directory");
        walk(va_of(3, 0, 12'h014), 1, 0, 0, 0, "R6 supervisor through supervisor directory");
        walk(va_of(6, 0, 12'h000), 1, 1, 0, 0, "R4 presence before protection");
        walk(va_of(1, 4, 12'h444), 1, 1, 0, 0, "R7 pass-through bits kept");
        walk(va_of(1, 5, 12'h555), 1, 1, 0, 0, "R8 marks already set");
        walk(va_of(1, 0, 12'h777), 0, 0, 0, 1, "R2 base captured at accept");
        base_reg = 32'h0003_0000;
        walk(va_of(1, 0, 12'h321), 0, 0, 0, 0, "R2 new base register value");
        chk(mem[32'h0002_0010] == 32'h0010_4FFF, "R7 stored pass-through entry",
            {96'h0, mem[32'h0002_0010]}, {96'h0, 32'h0010_4FFF});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule